// File: doc/BRIEF.md
# Eight-point fixed-point IDCT butterfly

This block performs a one-dimensional, eight-point inverse discrete cosine transform on signed 16-bit coefficients. It is bit-exact: every product is a 16-bit operand times a 14-bit fractional cosine constant, rounded to nearest and saturated back to 16 bits, and every plain addition or subtraction between stages wraps. A two-dimensional transform is built by running rows and then columns through this block. The surrounding logic handles ordering, transposition and pixel reconstruction.

The datapath is a four-stage pipeline with one register bank per butterfly stage. It accepts one vector of eight coefficients on every cycle in which the input valid flag is high. The matching vector of eight samples comes out with an output valid flag a fixed number of cycles later. Lanes travel packed on one bus, lane 0 in the least significant 16 bits.

Top module: `idct8_butterfly`

## Requirements
- R1: A vector sampled at a rising edge with `in_valid` high appears on `out_samp` with `out_valid` high right after the fourth rising edge, counting the sampling edge as the first. One vector can be accepted on every cycle, and every accepted vector produces exactly one output beat, in order.
- R2: Lane i of `in_coef` and `out_samp` occupies bits [16i+15:16i] in two's complement. The outputs y0..y7 follow this butterfly built from inputs x0..x7:
  - First level: keeps x0, x2, x4 and x6, and forms o4 = x1·3196 − x7·16069, o7 = x1·16069 + x7·3196, o5 = x5·13623 − x3·9102 and o6 = x5·9102 + x3·13623.
  - Second level: forms e0 = (x0+x4)·11585, e1 = (x0−x4)·11585, e2 = x2·6270 − x6·15137 and e3 = x2·15137 + x6·6270. It also forms u4 = o4+o5, u5 = o4−o5, u6 = o7−o6 and u7 = o6+o7.
  - Third level: forms f0 = e0+e3, f1 = e1+e2, f2 = e1−e2, f3 = e0−e3, f4 = u4, f5 = (u6−u5)·11585, f6 = (u6+u5)·11585 and f7 = u7.
  - Last level: yk = fk + f(7−k) and y(7−k) = fk − f(7−k) for k = 0..3.
- R3: Every constant product or product sum is formed in at least 32 bits, then 8192 is added and the result is shifted right arithmetically by 14, which rounds half up and rounds negatives toward minus infinity.
- R4: Every rounded product result is clamped to the range −32768..32767 before it is used further.
- R5: Plain additions and subtractions, including the sum and difference taken before a multiply by 11585, wrap modulo 2^16 and are not clamped.
- R6: An all-zero input vector produces an all-zero output vector.
- R7: An input with only x0 nonzero gives eight identical output lanes.
- R8: While `out_valid` is low, `out_samp` keeps its last value. Cycles with `in_valid` low produce no output beat.
- R9: After reset, `out_valid` is low and `out_samp` is all zero. A vector in flight when reset is asserted never appears at the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `in_coef` in this cycle |
| in_coef | input | 128 | Eight signed 16-bit coefficients, lane 0 lowest |
| out_valid | output | 1 | Qualifies `out_samp` in this cycle |
| out_samp | output | 128 | Eight signed 16-bit samples, lane 0 lowest |

## Verification
The bench uses the package defaults: 16-bit lanes, 14 fraction bits and a 32-bit product accumulator. This is the only width at which the rounding, clamping and wrapping rules are bit-exact, and it puts the full-scale corners within reach. Those corners are: a first-level rotation that overflows and must clamp, and a pre-multiply sum of 32767 and 1 that must wrap to −32768. Hand-computed vectors pin down rounding of negative products, the DC response and both corners. A streamed run of mixed full-scale and random vectors, with gaps, is compared against an integer reference of the butterfly.

// File: rtl/idct8_pkg.sv
package idct8_pkg;

    localparam int LANES     = 8;
    localparam int SAMP_W    = 16;
    localparam int FRAC_BITS = 14;
    localparam int ACC_W     = 32;
    localparam int STAGES    = 4;
    localparam int BUS_W     = LANES * SAMP_W;

    localparam int RND_BIAS  = 1 << (FRAC_BITS - 1);
    localparam int SAT_HI    = (1 << (SAMP_W - 1)) - 1;
    localparam int SAT_LO    = -(1 << (SAMP_W - 1));

    // cos(k*pi/64) scaled by 2^14, named by k
    localparam int CK4  = 16069;
    localparam int CK8  = 15137;
    localparam int CK12 = 13623;
    localparam int CK16 = 11585;
    localparam int CK20 = 9102;
    localparam int CK24 = 6270;
    localparam int CK28 = 3196;

    typedef logic signed [SAMP_W-1:0] samp_t;
    typedef samp_t [LANES-1:0]        lanes_t;

    // round to nearest (half up), scale down, clamp to the sample range
    function automatic samp_t round_sat(input logic signed [ACC_W-1:0] acc);
        logic signed [ACC_W-1:0] sh;
        sh = (acc + ACC_W'(RND_BIAS)) >>> FRAC_BITS;
        if (sh > ACC_W'(SAT_HI))
            return samp_t'(SAT_HI);
        else if (sh < ACC_W'(SAT_LO))
            return samp_t'(SAT_LO);
        else
            return sh[SAMP_W-1:0];
    endfunction

endpackage

// File: rtl/idct8_rot.sv
module idct8_rot
    import idct8_pkg::*;
#(
    parameter int K_A   = CK16,
    parameter int K_B   = CK16,
    parameter bit SHARE = 1'b0
) (
    input  samp_t a,
    input  samp_t b,
    output samp_t p,
    output samp_t q
);

    localparam logic signed [ACC_W-1:0] KA = ACC_W'(K_A);

    generate
        if (SHARE) begin : g_share
            // wrapped sum and difference, then one shared constant
            samp_t dif, sum;
            logic signed [ACC_W-1:0] dif_w, sum_w;
            assign dif   = a - b;
            assign sum   = a + b;
            assign dif_w = ACC_W'(dif);
            assign sum_w = ACC_W'(sum);
            assign p = round_sat(dif_w * KA);
            assign q = round_sat(sum_w * KA);
        end else begin : g_cross
            localparam logic signed [ACC_W-1:0] KB = ACC_W'(K_B);
            logic signed [ACC_W-1:0] a_w, b_w;
            assign a_w = ACC_W'(a);
            assign b_w = ACC_W'(b);
            assign p = round_sat(a_w * KA - b_w * KB);
            assign q = round_sat(a_w * KB + b_w * KA);
        end
    endgenerate

endmodule

// File: rtl/idct8_stage_reg.sv
module idct8_stage_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (en)
            q <= d;
    end

endmodule

// File: rtl/idct8_butterfly.sv
module idct8_butterfly
    import idct8_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [BUS_W-1:0] in_coef,
    output logic             out_valid,
    output logic [BUS_W-1:0] out_samp
);

    lanes_t nxt [STAGES];
    lanes_t cur [STAGES];
    logic   vld [STAGES+1];

    lanes_t x, c1, c2, c3;
    lanes_t st1_n, st2_n, st3_n, st4_n;

    assign x  = in_coef;
    assign c1 = cur[0];
    assign c2 = cur[1];
    assign c3 = cur[2];

    // ---------------- stage 1: odd-input rotations ----------------
    samp_t r17_p, r17_q, r53_p, r53_q;

    idct8_rot #(.K_A(CK28), .K_B(CK4), .SHARE(1'b0)) u_rot17 (
        .a(x[1]), .b(x[7]), .p(r17_p), .q(r17_q)
    );
    idct8_rot #(.K_A(CK12), .K_B(CK20), .SHARE(1'b0)) u_rot53 (
        .a(x[5]), .b(x[3]), .p(r53_p), .q(r53_q)
    );

    always_comb begin : s1_comb
        st1_n[0] = x[0];
        st1_n[1] = x[2];
        st1_n[2] = x[4];
        st1_n[3] = x[6];
        st1_n[4] = r17_p;
        st1_n[5] = r53_p;
        st1_n[6] = r53_q;
        st1_n[7] = r17_q;
    end

    // ---------------- stage 2: even rotations, odd butterflies ----
    samp_t r04_p, r04_q, r26_p, r26_q;

    idct8_rot #(.K_A(CK16), .K_B(CK16), .SHARE(1'b1)) u_rot04 (
        .a(c1[0]), .b(c1[2]), .p(r04_p), .q(r04_q)
    );
    idct8_rot #(.K_A(CK24), .K_B(CK8), .SHARE(1'b0)) u_rot26 (
        .a(c1[1]), .b(c1[3]), .p(r26_p), .q(r26_q)
    );

    always_comb begin : s2_comb
        st2_n[0] = r04_q;
        st2_n[1] = r04_p;
        st2_n[2] = r26_p;
        st2_n[3] = r26_q;
        st2_n[4] = c1[4] + c1[5];
        st2_n[5] = c1[4] - c1[5];
        st2_n[6] = c1[7] - c1[6];
        st2_n[7] = c1[6] + c1[7];
    end

    // ---------------- stage 3: even butterflies, middle rotation ---
    samp_t r65_p, r65_q;

    idct8_rot #(.K_A(CK16), .K_B(CK16), .SHARE(1'b1)) u_rot65 (
        .a(c2[6]), .b(c2[5]), .p(r65_p), .q(r65_q)
    );

    always_comb begin : s3_comb
        st3_n[0] = c2[0] + c2[3];
        st3_n[1] = c2[1] + c2[2];
        st3_n[2] = c2[1] - c2[2];
        st3_n[3] = c2[0] - c2[3];
        st3_n[4] = c2[4];
        st3_n[5] = r65_p;
        st3_n[6] = r65_q;
        st3_n[7] = c2[7];
    end

    // ---------------- stage 4: mirrored output butterfly -----------
    always_comb begin : s4_comb
        st4_n = '0;
        for (int k = 0; k < LANES / 2; k++) begin
            st4_n[k]           = c3[k] + c3[LANES-1-k];
            st4_n[LANES-1-k]   = c3[k] - c3[LANES-1-k];
        end
    end

    assign nxt[0] = st1_n;
    assign nxt[1] = st2_n;
    assign nxt[2] = st3_n;
    assign nxt[3] = st4_n;

    // ---------------- pipeline registers ---------------------------
    assign vld[0] = in_valid;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_pipe
            idct8_stage_reg #(.W(1)) u_vld (
                .clk(clk), .rst(rst), .en(1'b1),
                .d(vld[g]), .q(vld[g+1])
            );
            idct8_stage_reg #(.W(BUS_W)) u_dat (
                .clk(clk), .rst(rst), .en(vld[g]),
                .d(nxt[g]), .q(cur[g])
            );
        end
    endgenerate

    assign out_valid = vld[STAGES];
    assign out_samp  = cur[STAGES-1];

endmodule

// File: rtl/idct8_butterfly_chk.sv
module idct8_butterfly_chk
    import idct8_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [BUS_W-1:0] in_coef,
    input logic             out_valid,
    input logic [BUS_W-1:0] out_samp
);

    logic [2:0] since_rst;
    logic       prev_rst;

    always_ff @(posedge clk) begin
        prev_rst <= rst;
        if (rst)
            since_rst <= '0;
        else if (since_rst != 3'd7)
            since_rst <= since_rst + 3'd1;
    end

    // R1: output beat follows an accepted input by exactly four edges
    a_r1_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

    // R6: zero vector in, zero vector out
    a_r6_zero_in_zero_out: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_coef == '0) |-> ##4 (out_samp == '0));

    // R8: data bus only moves with a valid beat
    a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        ((since_rst >= 3'd1) && !out_valid) |-> $stable(out_samp));

    // R9: the cycle after reset shows an empty, cleared pipeline
    always @(posedge clk) begin
        if (prev_rst === 1'b1)
            a_r9_reset_clears: assert (!out_valid && out_samp == '0);
    end

endmodule

bind idct8_butterfly idct8_butterfly_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_coef(in_coef),
    .out_valid(out_valid), .out_samp(out_samp)
);

// File: tb/idct8_butterfly_test.sv
`timescale 1ns/1ps
module idct8_butterfly_test;

    localparam int NTAB   = 7;
    localparam int NSTRM  = 300;
    localparam int WD_CYC = 20000;

    // lanes written y7..y0 / x7..x0, lane 0 least significant
    localparam logic [127:0] TAB_IN [NTAB] = '{
        128'h0,
        {16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0040},
        {16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'hFFC0},
        {16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h7FFF},
        {16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h8000},
        {16'h0, 16'h0, 16'h0, 16'h0001, 16'h0, 16'h0, 16'h0, 16'h7FFF},
        {16'h8000, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h7FFF, 16'h0}
    };
    localparam logic [127:0] TAB_EXP [NTAB] = '{
        128'h0,
        {8{16'h002D}},
        {8{16'hFFD3}},
        {8{16'h5A81}},
        {8{16'hA57E}},
        {16'hA57E, 16'h5A81, 16'h5A81, 16'hA57E,
         16'hA57E, 16'h5A81, 16'h5A81, 16'hA57E},
        {16'h9B6F, 16'h1367, 16'h1365, 16'h8001,
         16'h7FFF, 16'hEC9B, 16'hEC99, 16'h6491}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [127:0] in_coef = '0;
    logic         out_valid;
    logic [127:0] out_samp;

    int n_chk = 0;
    int n_bad = 0;

    logic [127:0] exp_q [512];
    int wp = 0;
    int rp = 0;

    always #10 clk = ~clk;

    idct8_butterfly uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_coef(in_coef),
        .out_valid(out_valid), .out_samp(out_samp)
    );

    function automatic string tab_tag(input int i);
        case (i)
            0:       return "R6 zero vector";
            1:       return "R7 dc +64";
            2:       return "R3 rounding of negative product";
            3:       return "R7 dc full scale positive";
            4:       return "R7 dc full scale negative";
            5:       return "R5 wrapped pre-sum";
            default: return "R4 clamped rotation";
        endcase
    endfunction

    function automatic int w16(input int v);
        return int'(shortint'(v));
    endfunction

    function automatic int rs(input int acc);
        int r;
        r = (acc + 8192) >>> 14;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    // integer reference built from the R2..R5 formulas
    function automatic logic [127:0] ref_idct(input logic [127:0] v);
        int xi [8];
        int o [8];
        int e [8];
        int f [8];
        logic [127:0] res;
        for (int i = 0; i < 8; i++) xi[i] = int'($signed(v[16*i +: 16]));
        o[0] = xi[0]; o[1] = xi[2]; o[2] = xi[4]; o[3] = xi[6];
        o[4] = rs(xi[1] * 3196 - xi[7] * 16069);
        o[7] = rs(xi[1] * 16069 + xi[7] * 3196);
        o[5] = rs(xi[5] * 13623 - xi[3] * 9102);
        o[6] = rs(xi[5] * 9102 + xi[3] * 13623);
        e[0] = rs(w16(o[0] + o[2]) * 11585);
        e[1] = rs(w16(o[0] - o[2]) * 11585);
        e[2] = rs(o[1] * 6270 - o[3] * 15137);
        e[3] = rs(o[1] * 15137 + o[3] * 6270);
        e[4] = w16(o[4] + o[5]);
        e[5] = w16(o[4] - o[5]);
        e[6] = w16(o[7] - o[6]);
        e[7] = w16(o[6] + o[7]);
        f[0] = w16(e[0] + e[3]);
        f[1] = w16(e[1] + e[2]);
        f[2] = w16(e[1] - e[2]);
        f[3] = w16(e[0] - e[3]);
        f[4] = e[4];
        f[5] = rs(w16(e[6] - e[5]) * 11585);
        f[6] = rs(w16(e[6] + e[5]) * 11585);
        f[7] = e[7];
        for (int k = 0; k < 4; k++) begin
            res[16*k +: 16]     = 16'(f[k] + f[7-k]);
            res[16*(7-k) +: 16] = 16'(f[k] - f[7-k]);
        end
        return res;
    endfunction

    function automatic logic [15:0] pick_lane();
        case ($urandom % 5)
            0:       return 16'h7FFF;
            1:       return 16'h8000;
            2:       return 16'h0000;
            default: return 16'($urandom);
        endcase
    endfunction

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        n_bad++;
        $display("FAIL R1: watchdog expired, actual hang expected completion");
        finish_run();
    end

    initial begin
        // ---- reset state (R9)
        repeat (3) @(negedge clk);
        chk("R9 out_valid in reset", {127'b0, out_valid}, 128'h0);
        chk("R9 out_samp in reset", out_samp, 128'h0);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 out_valid after reset", {127'b0, out_valid}, 128'h0);

        // ---- table of hand-computed vectors
        for (int i = 0; i < NTAB; i++) begin
            in_coef  = TAB_IN[i];
            in_valid = 1'b1;
            @(negedge clk);
            in_valid = 1'b0;
            in_coef  = '1;            // must be ignored (R8)
            @(negedge clk);
            @(negedge clk);
            chk("R1 no beat before fourth edge", {127'b0, out_valid}, 128'h0);
            @(negedge clk);
            chk("R1 beat after fourth edge", {127'b0, out_valid}, 128'h1);
            chk(tab_tag(i), out_samp, TAB_EXP[i]);
            @(negedge clk);
            chk("R8 valid drops after single beat", {127'b0, out_valid}, 128'h0);
            chk("R8 data held while idle", out_samp, TAB_EXP[i]);
        end

        // ---- streamed vectors with gaps against the reference (R2)
        for (int cyc = 0; cyc < NSTRM + 6; cyc++) begin
            @(negedge clk);
            if (out_valid) begin
                if (rp < wp)
                    chk("R2 streamed vector", out_samp, exp_q[rp]);
                else
                    chk("R8 unexpected beat", 128'h1, 128'h0);
                rp++;
            end
            if (cyc < NSTRM && ($urandom % 4) != 0) begin
                logic [127:0] v;
                for (int l = 0; l < 8; l++) v[16*l +: 16] = pick_lane();
                in_coef   = v;
                in_valid  = 1'b1;
                exp_q[wp] = ref_idct(v);
                wp++;
            end else begin
                in_valid = 1'b0;
                in_coef  = 128'(cyc);
            end
        end
        chk("R1 one beat per accepted vector", 128'(rp), 128'(wp));

        // ---- reset with a vector in flight (R9)
        in_coef  = TAB_IN[1];
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        rst      = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk("R9 flushed vector never emerges", {127'b0, out_valid}, 128'h0);
        end
        chk("R9 data cleared by reset", out_samp, 128'h0);

        finish_run();
    end

endmodule